// File: doc/BRIEF.md
# Flash Operation Sequencer with Protection

This block runs self-timed erase, program and CRC operations on a small embedded flash array for a CPU. The CPU issues a command with a one-cycle `cmd_valid` strobe. The block accepts it only while idle, and it holds `cpu_stall` high until the operation has ended. An operation ends in one of two ways: the timed duration runs out, or an interrupt, a high-voltage fault or a security refusal cuts it short. When the operation ends, the block pulses `done` and shows a status byte with the carry-style error flag `err_carry`. After a program cycle the block reads the location back and compares it with the intended value.

The block also holds two protection bits, a configuration write lock and a disable-clear bit, and one configuration byte. Writes to the configuration byte are refused while the lock is set. A boot-status write can only set the two protection bits. The clear-protection command removes the lock, but the programming mode decides whether that command is accepted.

The sequencer has four states, and the transitions between them are named here:
- IDLE goes to BUSY on *start* (a timed operation that is not refused), or to FINISH on *immediate* (any other command).
- BUSY goes to FINISH on *abort* (an interrupt or a fault) or on *expire* (the timer ends an erase or a CRC). It goes to VERIFY on *expire* of a program.
- VERIFY goes to FINISH on *compare*.
- FINISH goes to IDLE on *release*.

Top module: `flash_seq`

## Requirements
- R1: Timing of accepted commands.
  - Once a timed command (op 0 erase, 1 program, 2 CRC) is accepted, `cpu_stall` stays high until `done` has been shown.
  - Counted from the accepting clock edge, `done` is visible after ERASE_CYC cycles for an erase, PROG_CYC+1 cycles for a program, and CRC_CYC cycles for a CRC.
  - `cmd_valid` is ignored while the block is not idle.
- R2: An `irq_req` sampled high in any BUSY cycle aborts the operation, including the last cycle, where the abort takes precedence over completion.
  - `done` is visible in the following cycle.
  - Status bit 0 is set, and the array is unchanged.
- R3: A timed command accepted while `sec_block` is high never enters BUSY.
  - `done` is visible right after the accepting edge.
  - Status bit 1 is set, the array is unchanged, and `crc_valid` is 0.
- R4: An `hv_err_in` sampled high in a BUSY cycle aborts the operation and sets status bit 2.
  - When the interrupt and the fault arrive in the same cycle, both bit 0 and bit 2 are set.
- R5: Program writes and their read-back check.
  - A program writes the old byte AND the command data into the addressed location.
  - The read-back check sets status bit 3 when the stored byte differs from the command data, or when `rb_locked` is high during the check.
- R6: Status byte and error flag.
  - Status bits 7..4 read 0.
  - `err_carry` is 1 exactly when any of status bits 3..0 is 1.
  - The status is cleared when a command is accepted and is held until the next command is accepted.
- R7: Configuration write (op 3).
  - With `cfg_wp` = 1 it leaves `cfg_byte` unchanged and sets status bit 1.
  - With `cfg_wp` = 0 it loads `cmd_data` into `cfg_byte`.
- R8: Boot-status write (op 4). `cmd_data[0]` = 1 sets `cfg_wp` and `cmd_data[1]` = 1 sets `clr_dis`. Zero bits leave both bits unchanged.
- R9: Clear-protection command (op 5), with `prog_mode` 0 = IAP, 1 = ISP, 2 = ICP and 3 = parallel.
  - In modes 0 and 1 with `clr_dis` = 1 it is refused: status bit 1 is set and `cfg_wp` is kept.
  - Otherwise it clears `cfg_wp`, and in modes 2 and 3 it also clears `clr_dis`.
- R10: `done` is a single-cycle pulse.
  - Commands 3, 4, 5, 6 and 7 show `done` right after the accepting edge.
  - Codes 6 and 7 have no effect and report status 0.
- R11: Erase and CRC results.
  - An erase that completes sets every array byte to 8'hFF.
  - `crc_valid` is set by a CRC that completes and is cleared when any command is accepted.
- R12: After reset, the block is idle with the following values:
  - `done` = 0, `cpu_stall` = 0 and status 0.
  - `cfg_wp` = 0, `clr_dis` = 0 and `cfg_byte` = 0.
  - Every array byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only in IDLE |
| cmd_op | input | 3 | Command code |
| cmd_addr | input | AW | Target array address |
| cmd_data | input | DW | Program data, config data or boot-status bits |
| prog_mode | input | 2 | Programming mode (IAP, ISP, ICP, parallel) |
| irq_req | input | 1 | Interrupt request, aborts a running cycle |
| hv_err_in | input | 1 | High-voltage fault, aborts a running cycle |
| sec_block | input | 1 | Security refusal for the command being accepted |
| rb_locked | input | 1 | Read-back protection of the programmed location |
| rd_addr | input | AW | Direct read address |
| rd_data | output | DW | Array contents at `rd_addr` |
| cpu_stall | output | 1 | CPU held in program-idle |
| done | output | 1 | End-of-command pulse |
| err_carry | output | 1 | Error flag for the CPU |
| status | output | 8 | Error status byte |
| crc_valid | output | 1 | Last CRC completed normally |
| cfg_wp | output | 1 | Configuration write lock |
| clr_dis | output | 1 | Disable-clear bit |
| cfg_byte | output | DW | Configuration byte |

## Verification
Every result has a fixed due cycle, counted from the edge that accepts the command:
- immediate commands: `done` after 0 further edges;
- aborts: after the edge that sampled the interrupt or fault;
- erase and CRC: after their cycle count;
- program: one edge more.

The bench drives at the falling edge and counts rising edges until it sees `done`. It compares that count with the due value from the requirements. The status, flags, configuration state and a full array sweep are read at the falling edges after `done`. The bench sweeps the interrupt and fault injection point over every BUSY cycle, and it runs the clear command through all four modes crossed with both states of the disable bit.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam logic [2:0] OP_ERASE   = 3'd0;
    localparam logic [2:0] OP_PROG    = 3'd1;
    localparam logic [2:0] OP_CRC     = 3'd2;
    localparam logic [2:0] OP_CFGWR   = 3'd3;
    localparam logic [2:0] OP_BOOTWR  = 3'd4;
    localparam logic [2:0] OP_CLRPROT = 3'd5;

    localparam int ST_INTR = 0;
    localparam int ST_SEC  = 1;
    localparam int ST_HV   = 2;
    localparam int ST_VERF = 3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_BUSY,
        S_VERIFY,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/flash_timer.sv
module flash_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CW'(1));

    // R1
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> cnt_q != '0);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_all,
    input  logic          prog_we,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic [AW-1:0] va_addr,
    output logic [DW-1:0] va_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[w] <= '1;
            else if (erase_all)
                mem_q[w] <= '1;
            else if (prog_we && prog_addr == AW'(w))
                mem_q[w] <= mem_q[w] & prog_data;
        end
    end

    assign va_data = mem_q[va_addr];
    assign rb_data = mem_q[rb_addr];

    // R11
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_all && prog_we));
endmodule

// File: rtl/flash_prot.sv
module flash_prot #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          boot_we,
    input  logic [1:0]    boot_bits,
    input  logic          clr_req,
    input  logic [1:0]    mode,
    output logic          wp,
    output logic          dis,
    output logic [DW-1:0] cfg_byte,
    output logic          cfg_rej,
    output logic          clr_ok
);
    logic          wp_q, dis_q;
    logic [DW-1:0] cfg_q;

    // mode[1] marks ICP (2) and parallel (3)
    assign clr_ok  = !dis_q || mode[1];
    assign cfg_rej = cfg_we && wp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= 1'b0;
            dis_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            if (cfg_we && !wp_q)
                cfg_q <= cfg_wdata;
            if (boot_we) begin
                wp_q  <= wp_q  | boot_bits[0];
                dis_q <= dis_q | boot_bits[1];
            end else if (clr_req && clr_ok) begin
                wp_q <= 1'b0;
                if (mode[1])
                    dis_q <= 1'b0;
            end
        end
    end

    assign wp       = wp_q;
    assign dis      = dis_q;
    assign cfg_byte = cfg_q;

    // R7
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wp_q) |=> $stable(cfg_q));
    // R9
    clr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && dis_q && !mode[1]) |=> (wp_q == $past(wp_q)));
    // R9
    clr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !dis_q) |=> !wp_q);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int ERASE_CYC = 12,
    parameter int PROG_CYC  = 5,
    parameter int CRC_CYC   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [1:0]    prog_mode,
    input  logic          irq_req,
    input  logic          hv_err_in,
    input  logic          sec_block,
    input  logic          rb_locked,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          cpu_stall,
    output logic          done,
    output logic          err_carry,
    output logic [7:0]    status,
    output logic          crc_valid,
    output logic          cfg_wp,
    output logic          clr_dis,
    output logic [DW-1:0] cfg_byte
);
    localparam int MAXC_A = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAXC   = (MAXC_A > CRC_CYC) ? MAXC_A : CRC_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    seq_state_e    st_q, st_d;
    logic [2:0]    op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [3:0]    sts_q;
    logic          crc_ok_q;

    logic          accept, timed, go_busy, abort, expire;
    logic [CW-1:0] dur;
    logic          tmr_last;
    logic [DW-1:0] va_data;
    logic          cfg_rej, clr_ok;

    assign accept  = cmd_valid && (st_q == S_IDLE);
    assign timed   = (cmd_op == OP_ERASE) || (cmd_op == OP_PROG) || (cmd_op == OP_CRC);
    assign go_busy = accept && timed && !sec_block;
    assign abort   = (st_q == S_BUSY) && (irq_req || hv_err_in);
    assign expire  = (st_q == S_BUSY) && tmr_last && !abort;

    always_comb begin
        unique case (cmd_op)
            OP_ERASE: dur = CW'(ERASE_CYC);
            OP_PROG:  dur = CW'(PROG_CYC);
            default:  dur = CW'(CRC_CYC);
        endcase
    end

    flash_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go_busy),
        .load_val (dur),
        .dec      (st_q == S_BUSY),
        .last     (tmr_last)
    );

    flash_array #(.AW(AW), .DW(DW)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_all (expire && op_q == OP_ERASE),
        .prog_we   (expire && op_q == OP_PROG),
        .prog_addr (addr_q),
        .prog_data (data_q),
        .va_addr   (addr_q),
        .va_data   (va_data),
        .rb_addr   (rd_addr),
        .rb_data   (rd_data)
    );

    flash_prot #(.DW(DW)) prot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (accept && cmd_op == OP_CFGWR),
        .cfg_wdata (cmd_data),
        .boot_we   (accept && cmd_op == OP_BOOTWR),
        .boot_bits (cmd_data[1:0]),
        .clr_req   (accept && cmd_op == OP_CLRPROT),
        .mode      (prog_mode),
        .wp        (cfg_wp),
        .dis       (clr_dis),
        .cfg_byte  (cfg_byte),
        .cfg_rej   (cfg_rej),
        .clr_ok    (clr_ok)
    );

    // next state: start, immediate, abort, expire, compare, release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (accept) st_d = go_busy ? S_BUSY : S_FINISH;
            S_BUSY:   if (abort) st_d = S_FINISH;
                      else if (tmr_last) st_d = (op_q == OP_PROG) ? S_VERIFY : S_FINISH;
            S_VERIFY: st_d = S_FINISH;
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // command capture, status and CRC result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            sts_q    <= '0;
            crc_ok_q <= 1'b0;
        end else if (accept) begin
            op_q     <= cmd_op;
            addr_q   <= cmd_addr;
            data_q   <= cmd_data;
            crc_ok_q <= 1'b0;
            sts_q    <= '0;
            sts_q[ST_SEC] <= (timed && sec_block) || cfg_rej
                           || (cmd_op == OP_CLRPROT && !clr_ok);
        end else begin
            if (st_q == S_BUSY) begin
                if (irq_req)   sts_q[ST_INTR] <= 1'b1;
                if (hv_err_in) sts_q[ST_HV]   <= 1'b1;
            end
            if (st_q == S_VERIFY && (va_data != data_q || rb_locked))
                sts_q[ST_VERF] <= 1'b1;
            if (expire && op_q == OP_CRC)
                crc_ok_q <= 1'b1;
        end
    end

    assign cpu_stall = (st_q != S_IDLE);
    assign done      = (st_q == S_FINISH);
    assign status    = {4'b0000, sts_q};
    assign err_carry = |sts_q;
    assign crc_valid = crc_ok_q;

    // R1
    start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_busy |=> (cpu_stall && !done));
    // R2
    irq_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BUSY && irq_req) |=> (done && status[ST_INTR]));
    // R3
    sec_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && timed && sec_block) |=> (done && status[ST_SEC] && !crc_valid));
    // R4
    hv_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BUSY && hv_err_in) |=> (done && status[ST_HV]));
    // R5
    locked_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_VERIFY && rb_locked) |=> status[ST_VERF]);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NE = 12;
    localparam int NP = 5;
    localparam int NC = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [1:0]    prog_mode = '0;
    logic          irq_req = 1'b0, hv_err_in = 1'b0, sec_block = 1'b0, rb_locked = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data, cfg_byte;
    logic          cpu_stall, done, err_carry, crc_valid, cfg_wp, clr_dis;
    logic [7:0]    status;

    int total = 0;
    int fails = 0;

    logic [7:0] m_mem [DEPTH];
    logic [7:0] m_cfg = '0;
    bit m_wp = 0, m_dis = 0;

    always #2.5 clk = ~clk;

    flash_seq #(.AW(AW), .DW(DW), .ERASE_CYC(NE), .PROG_CYC(NP), .CRC_CYC(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prog_mode(prog_mode),
        .irq_req(irq_req), .hv_err_in(hv_err_in), .sec_block(sec_block),
        .rb_locked(rb_locked), .rd_addr(rd_addr), .rd_data(rd_data),
        .cpu_stall(cpu_stall), .done(done), .err_carry(err_carry), .status(status),
        .crc_valid(crc_valid), .cfg_wp(cfg_wp), .clr_dis(clr_dis), .cfg_byte(cfg_byte)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic mem_sweep(input string req);
        int bad = -1;
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            #1;
            if (rd_data !== m_mem[a] && bad < 0) bad = a;
        end
        chk(bad < 0, req, "array sweep first bad addr", bad, -1);
    endtask

    task automatic run_op(input int op, input int addr, input int dat, input int mode,
                          input bit sec, input bit rp, input int irq_at, input int hv_at,
                          input string tag);
        int n, exp_lat, abort_j, dur;
        logic [7:0] exp_st;
        bit exp_crc, stall_bad;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_addr = AW'(addr); cmd_data = 8'(dat);
        prog_mode = 2'(mode); sec_block = sec; rb_locked = rp;
        @(posedge clk);
        n = 0; stall_bad = 0;
        while (n < 200) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (done) break;
            if (!cpu_stall) stall_bad = 1;
            irq_req   = (irq_at == n + 1);
            hv_err_in = (hv_at == n + 1);
            // a second command while busy must be ignored (R1)
            cmd_valid = (n == 0);
            cmd_op = 3'd3; cmd_data = 8'hA5;
            @(posedge clk);
            n++;
        end
        irq_req = 0; hv_err_in = 0; cmd_valid = 0;
        exp_st = 0; exp_crc = 0; exp_lat = 0;
        if (op <= 2) begin
            dur = (op == 0) ? NE : (op == 1) ? NP : NC;
            if (sec) exp_st = 8'h02;
            else begin
                abort_j = 0;
                if (irq_at >= 1 && irq_at <= dur) abort_j = irq_at;
                if (hv_at >= 1 && hv_at <= dur && (abort_j == 0 || hv_at < abort_j)) abort_j = hv_at;
                if (abort_j != 0) begin
                    exp_lat = abort_j;
                    if (irq_at == abort_j) exp_st |= 8'h01;
                    if (hv_at == abort_j)  exp_st |= 8'h04;
                end else begin
                    exp_lat = dur;
                    if (op == 0) for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hFF;
                    else if (op == 1) begin
                        m_mem[addr] = m_mem[addr] & 8'(dat);
                        if (m_mem[addr] != 8'(dat) || rp) exp_st |= 8'h08;
                        exp_lat = dur + 1;
                    end else exp_crc = 1;
                end
            end
        end else if (op == 3) begin
            if (m_wp) exp_st = 8'h02; else m_cfg = 8'(dat);
        end else if (op == 4) begin
            if (dat[0]) m_wp = 1;
            if (dat[1]) m_dis = 1;
        end else if (op == 5) begin
            if (m_dis && mode < 2) exp_st = 8'h02;
            else begin m_wp = 0; if (mode >= 2) m_dis = 0; end
        end
        chk(n == exp_lat, "R1", {tag, " done latency"}, n, exp_lat);
        chk(status == exp_st, tag, "status byte", int'(status), int'(exp_st));
        chk(err_carry == (exp_st != 0), "R6", "err_carry", int'(err_carry), int'(exp_st != 0));
        chk(crc_valid == exp_crc, "R11", "crc_valid", int'(crc_valid), int'(exp_crc));
        chk(!stall_bad, "R1", "stall held while busy", int'(stall_bad), 0);
        @(negedge clk);
        chk(!done, "R10", "done single pulse", int'(done), 0);
        chk(status == exp_st, "R6", "status held after done", int'(status), int'(exp_st));
        chk(cfg_wp == m_wp && clr_dis == m_dis, "R9", "protection bits {wp,dis}",
            int'({cfg_wp, clr_dis}), int'({m_wp, m_dis}));
        chk(cfg_byte == m_cfg, "R7", "cfg_byte", int'(cfg_byte), int'(m_cfg));
        mem_sweep(tag);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) m_mem[a] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !cpu_stall && status == 0 && !err_carry, "R12", "reset outputs",
            int'({done, cpu_stall, status}), 0);
        chk(!cfg_wp && !clr_dis && cfg_byte == 0, "R12", "reset protection",
            int'({cfg_wp, clr_dis, cfg_byte}), 0);
        mem_sweep("R12");

        // R5 program every location of an erased array
        for (int a = 0; a < DEPTH; a++)
            run_op(1, a, (a * 37 + 11) & 255, 0, 0, 0, 0, 0, "R5");
        // R5 program ones over zeros -> mismatch
        run_op(1, 3, 8'hFF, 0, 0, 0, 0, 0, "R5");
        // R5 locked location still reports verify error
        run_op(1, 5, (5 * 37 + 11) & 255, 0, 0, 1, 0, 0, "R5");
        // R11 erase and CRC completion
        run_op(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        run_op(2, 0, 0, 0, 0, 0, 0, 0, "R11");
        // R2 interrupt at every busy cycle
        for (int j = 1; j <= NP; j++) run_op(1, j, 8'h0F, 0, 0, 0, j, 0, "R2");
        run_op(0, 0, 0, 1, 0, 0, NE, 0, "R2");
        run_op(2, 0, 0, 0, 0, 0, NC, 0, "R2");
        // R4 fault at every CRC cycle, and coincident with interrupt
        for (int j = 1; j <= NC; j++) run_op(2, 0, 0, 0, 0, 0, 0, j, "R4");
        run_op(1, 9, 8'h00, 0, 0, 0, 3, 3, "R4");
        run_op(0, 0, 0, 0, 0, 0, 0, NE, "R4");
        // R3 security refusal of each timed op
        for (int op = 0; op <= 2; op++) run_op(op, 2, 8'h00, 0, 1, 0, 0, 0, "R3");
        // R7/R8/R9 protection matrix
        for (int md = 0; md < 4; md++)
            for (int d = 0; d < 2; d++) begin
                run_op(5, 0, 0, 2, 0, 0, 0, 0, "R9");
                run_op(4, 0, (d << 1) | 1, md, 0, 0, 0, 0, "R8");
                run_op(3, 0, 8'h30 + md * 2 + d, md, 0, 0, 0, 0, "R7");
                run_op(5, 0, 0, md, 0, 0, 0, 0, "R9");
                run_op(3, 0, 8'h60 + md * 2 + d, md, 0, 0, 0, 0, "R7");
            end
        run_op(4, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R10 unused codes
        run_op(6, 1, 8'h00, 0, 0, 0, 0, 0, "R10");
        run_op(7, 1, 8'h00, 0, 0, 0, 0, 0, "R10");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule